// File: doc/BRIEF.md
# Dynamically Sized External Bus Master

This block turns one operand request from the processor side into one or more strobed cycles on an asynchronous 16-bit external bus. A request carries a byte address, a direction, an operand length of one to four bytes, an address-space selector and, for writes, the operand. The block drives address, strobe, direction, a remaining-byte count and a space code. It then waits for the responding device to return a width acknowledge.

Each acknowledge tells the master how wide the responding port is. That width decides how many bytes the cycle moved. The master advances the address, lowers the remaining count and starts another cycle until the operand is complete. Read bytes are gathered in big-endian order and handed back with a one-clock completion pulse. The acknowledge can come from the external pins or from an internal chip-select source; the two are combined by OR. The result is brought into the clock domain through two flops before the master acts on it.

Top module: `ebus_seq`

## Requirements
- R1: `rw` changes only in the clock where `as_n` falls (start of a cycle), and `rw`, `bus_addr`, `siz` and `fc` hold steady for as long as `as_n` stays low.
- R2: `rw` is 1 for reads and 0 for writes, and it does not toggle between consecutive cycles of the same direction, including across separate operands.
- R3: While `as_n` is low, `siz` gives the bytes still to move for the operand (01 = 1, 10 = 2, 11 = 3, 00 = 4) and `bus_addr` gives the address of the next byte.
- R4: `fc` is 101 for data (`req_space` 01 or 00), 110 for program (`req_space` 10) and 111 for control (`req_space` 11); bit 2 is always 1 and 100 is never driven.
- R5: The asserted-level acknowledge is `~dsack_n | ~cs_dsack_n`, bit 1 being the high bit. Value 00 holds the cycle open (wait), 01 means an 8-bit port, and 10 or 11 mean a 16-bit port. Either source alone ends a cycle.
- R6: After an 8-bit acknowledge, the address and the remaining count both move by one. After a 16-bit acknowledge they move by two, except by one when the address is odd or only one byte remains.
- R7: Acknowledge inputs pass two synchronizing flops. `as_n` rises on the third rising edge after the acknowledge appears. A following strobe waits until the synchronized acknowledge reads 00, so with an acknowledge that is dropped right after the strobe rises, there are exactly three high sample points between cycles.
- R8: Lanes are big-endian: `din[15:8]`/`dout[15:8]` carry even addresses and `[7:0]` carry odd addresses. An 8-bit port uses the upper lane. On a write cycle with an odd address or one byte left, the active byte is driven on both lanes. Read data returns right-aligned, with the lowest-addressed byte most significant.
- R9: `busy` is high from the clock after acceptance until the operand ends. `done` then pulses for one clock while `busy` is low, with `rdata` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Operand request, taken while idle |
| req_write | input | 1 | 1 = write operand |
| req_size | input | 2 | Operand length, same code as `siz` |
| req_space | input | 2 | 01/00 data, 10 program, 11 control |
| req_addr | input | AW | Byte address of the operand |
| req_wdata | input | 32 | Write operand, right-aligned |
| busy | output | 1 | Operand in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read operand, right-aligned |
| bus_addr | output | AW | External address |
| as_n | output | 1 | Address strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |
| siz | output | 2 | Remaining byte count |
| fc | output | 3 | Address-space code |
| dout | output | 16 | Write data lanes |
| din | input | 16 | Read data lanes |
| dsack_n | input | 2 | External width acknowledge, active low |
| cs_dsack_n | input | 2 | Internal chip-select acknowledge, active low |

## Verification
Operands of every length are run at even and odd addresses against an 8-bit port, a 16-bit port and a port that alternates its width on every cycle. Together these separate the step rules for narrow, wide, misaligned and last-byte cycles. The read lanes not used by a cycle carry filler bytes, so taking a byte from the wrong lane changes the returned operand. Writes are checked byte by byte in the device memory. Wait states and acknowledges arriving only from the chip-select input confirm that the cycle stays open and that the strobe timing counts the two synchronizing flops. Runs of writes next to reads, and the three address spaces, show whether the direction and space codes change only where they should.

// File: rtl/ebus_seq.sv
module ebus_seq #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rdata,
  output logic [AW-1:0] bus_addr,
  output logic          as_n,
  output logic          rw,
  output logic [1:0]    siz,
  output logic [2:0]    fc,
  output logic [15:0]   dout,
  input  logic [15:0]   din,
  input  logic [1:0]    dsack_n,
  input  logic [1:0]    cs_dsack_n
);

  typedef enum logic [1:0] {IDLE, STRB, NEG} st_t;
  st_t st;

  logic [1:0]    s1, s2;
  logic [2:0]    cnt;
  logic [1:0]    sp;
  logic [AW-1:0] a;
  logic [31:0]   wbuf, rbuf;

  wire        odd  = a[0];
  wire        two  = s2[1] && !odd && (cnt > 3'd1);
  wire [2:0]  step = two ? 3'd2 : 3'd1;
  wire [7:0]  rb   = (s2[1] && odd) ? din[7:0] : din[15:8];
  wire [2:0]  nb   = {req_size == 2'b00, req_size};
  wire [2:0]  gap  = 3'd4 - nb;
  wire [5:0]  sh   = {gap, 3'b000};

  assign busy     = (st != IDLE);
  assign rdata    = rbuf;
  assign bus_addr = a;
  assign siz      = cnt[1:0];
  assign fc       = {1'b1, sp};
  assign dout     = (odd || cnt == 3'd1) ? {wbuf[31:24], wbuf[31:24]} : wbuf[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b00;
      s2 <= 2'b00;
    end else begin
      s1 <= ~dsack_n | ~cs_dsack_n;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      as_n <= 1'b1;
      rw   <= 1'b1;
      cnt  <= 3'd0;
      sp   <= 2'b01;
      a    <= '0;
      wbuf <= '0;
      rbuf <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          a    <= req_addr;
          cnt  <= nb;
          sp   <= (req_space == 2'b00) ? 2'b01 : req_space;
          rw   <= !req_write;
          wbuf <= req_wdata << sh;
          rbuf <= '0;
          as_n <= 1'b0;
          st   <= STRB;
        end
        STRB: if (s2 != 2'b00) begin
          as_n <= 1'b1;
          st   <= NEG;
          a    <= a + AW'(step);
          cnt  <= cnt - step;
          wbuf <= two ? (wbuf << 16) : (wbuf << 8);
          rbuf <= two ? {rbuf[15:0], din} : {rbuf[23:0], rb};
        end
        NEG: if (s2 == 2'b00) begin
          if (cnt == 3'd0) begin
            st   <= IDLE;
            done <= 1'b1;
          end else begin
            as_n <= 1'b0;
            st   <= STRB;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_RW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !$past(as_n)) |-> ($stable(rw) && $stable(fc))); // R1
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !$past(as_n)) |-> ($stable(siz) && $stable(bus_addr))); // R3
  AST_SPACE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> (fc[2] && fc != 3'b100)); // R4
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && s2 != 2'b00) |=> as_n); // R7
  AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n) |-> ($past(s2) == 2'b00)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && as_n)); // R9

endmodule

// File: tb/sim_ebus_seq.sv
module sim_ebus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b01, req_space = 2'b01;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, as_n, rw;
  logic [31:0] rdata;
  logic [23:0] bus_addr;
  logic [1:0]  siz;
  logic [2:0]  fc;
  logic [15:0] dout;
  logic [15:0] din = '0;
  logic [1:0]  dsack_n = 2'b11, cs_dsack_n = 2'b11;

  always #10 clk = ~clk;

  ebus_seq #(.AW(24)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_space(req_space), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .as_n(as_n), .rw(rw), .siz(siz), .fc(fc),
    .dout(dout), .din(din), .dsack_n(dsack_n), .cs_dsack_n(cs_dsack_n));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  logic [7:0]  mem [0:255];
  int          dev_mode = 1, dev_wait = 0;
  bit          dev_cs = 0, dev_acked = 0, alt = 0;
  int          dev_wc = 0;
  logic [23:0] e_addr = '0;
  int          e_cnt = 0;
  bit          e_rw = 1;
  logic [2:0]  e_fc = 3'b101;
  bit          last_as = 1, last_rw = 1, op_mid = 0;
  int          low_cnt = 0, hi_run = 0, ncyc = 0;
  logic [23:0] h_addr;
  logic [1:0]  h_siz;

  always @(negedge clk) if (rst_n) begin
    if (rw !== last_rw)
      chk(!as_n && last_as, "R1", "rw changed outside cycle start", {31'd0, rw}, {31'd0, last_rw});
    if (!as_n && last_as) begin
      if (op_mid) chk(hi_run == 3, "R7", "strobe high gap", hi_run, 3);
      op_mid = 1;
      ncyc++;
      h_addr = bus_addr; h_siz = siz;
      chk(bus_addr == e_addr, "R3", "cycle address", {8'd0, bus_addr}, {8'd0, e_addr});
      chk(siz == e_cnt[1:0], "R3", "size lines", {30'd0, siz}, {30'd0, e_cnt[1:0]});
      chk(fc == e_fc, "R4", "function code", {29'd0, fc}, {29'd0, e_fc});
      chk(rw == e_rw, "R2", "direction", {31'd0, rw}, {31'd0, e_rw});
    end else if (!as_n) begin
      chk(bus_addr == h_addr && siz == h_siz, "R1", "address/size held",
          {6'd0, siz, bus_addr}, {6'd0, h_siz, h_addr});
    end
    if (!as_n) begin
      low_cnt++; hi_run = 0;
    end else hi_run++;

    if (!as_n) begin
      if (!dev_acked) begin
        if (dev_wc >= dev_wait) begin
          bit w8;
          int st;
          logic [1:0] code;
          w8 = (dev_mode == 0) || (dev_mode == 2 && !alt);
          alt = !alt;
          code = w8 ? 2'b01 : ((dev_mode == 2) ? 2'b11 : 2'b10);
          if (dev_cs) cs_dsack_n = ~code; else dsack_n = ~code;
          if (rw) begin
            if (w8) din = {mem[bus_addr[7:0]], 8'hEE};
            else if (bus_addr[0]) din = {8'hDD, mem[bus_addr[7:0]]};
            else din = {mem[bus_addr[7:0]], mem[bus_addr[7:0] + 8'd1]};
          end else begin
            if (bus_addr[0] || siz == 2'b01)
              chk(dout[15:8] == dout[7:0], "R8", "single byte on both lanes", {16'd0, dout}, {16'd0, dout[15:8], dout[15:8]});
            if (w8) mem[bus_addr[7:0]] = dout[15:8];
            else if (bus_addr[0]) mem[bus_addr[7:0]] = dout[7:0];
            else begin
              mem[bus_addr[7:0]] = dout[15:8];
              if (siz != 2'b01) mem[bus_addr[7:0] + 8'd1] = dout[7:0];
            end
          end
          st = (w8 || e_addr[0] || e_cnt == 1) ? 1 : 2;
          e_addr = e_addr + 24'(st);
          e_cnt  = e_cnt - st;
          dev_acked = 1;
        end else dev_wc++;
      end
    end else begin
      dsack_n = 2'b11; cs_dsack_n = 2'b11; dev_acked = 0; dev_wc = 0;
    end
    last_as = as_n; last_rw = rw;
  end

  task automatic op(input bit wr, input int n, input logic [23:0] ad,
                    input logic [31:0] wd, input logic [1:0] space);
    logic [31:0] exp;
    bit seen;
    exp = 0;
    for (int k = 0; k < n; k++) exp = (exp << 8) | {24'd0, mem[ad[7:0] + 8'(k)]};
    @(negedge clk);
    e_addr = ad; e_cnt = n; e_rw = !wr;
    e_fc = {1'b1, (space == 2'b00) ? 2'b01 : space};
    op_mid = 0; low_cnt = 0; ncyc = 0; alt = 0;
    req_valid = 1; req_write = wr; req_size = 2'(n); req_addr = ad;
    req_wdata = wd; req_space = space;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R9", "busy after accept", {31'd0, busy}, 1);
    seen = 0;
    for (int t = 0; t < 400 && !seen; t++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen && !busy, "R9", "done pulse with busy low", {30'd0, seen, busy}, 32'd2);
    chk(e_cnt == 0, "R6", "bytes left at done", e_cnt, 0);
    chk(low_cnt == ncyc * (dev_wait + 3), "R7", "strobe low sample points",
        low_cnt, ncyc * (dev_wait + 3));
    if (wr) begin
      for (int k = 0; k < n; k++)
        chk(mem[ad[7:0] + 8'(k)] == wd[8*(n-1-k) +: 8], "R8", "written byte",
            {24'd0, mem[ad[7:0] + 8'(k)]}, {24'd0, wd[8*(n-1-k) +: 8]});
    end else
      chk(rdata == exp, "R8", "read operand", rdata, exp);
    @(negedge clk);
    chk(!done, "R9", "done one clock", {31'd0, done}, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(as_n && !busy && !done && rw, "R9", "reset state",
        {28'd0, as_n, busy, done, rw}, 32'b1001);
    rst_n = 1;
    // R6 16-bit port, aligned and misaligned
    dev_mode = 1; dev_wait = 0;
    op(0, 4, 24'h10, 0, 2'b01);
    op(0, 4, 24'h21, 0, 2'b01);
    op(0, 3, 24'h16, 0, 2'b01);
    op(0, 1, 24'h18, 0, 2'b01);
    // R8 8-bit port on the upper lane
    dev_mode = 0;
    op(0, 3, 24'h30, 0, 2'b01);
    op(1, 2, 24'h33, 32'h0000_A1B2, 2'b01);
    // R2 back-to-back writes on a 16-bit port
    dev_mode = 1;
    op(1, 4, 24'h40, 32'hC0DE_F00D, 2'b01);
    op(1, 2, 24'h45, 32'h0000_1357, 2'b01);
    op(1, 1, 24'h48, 32'h0000_009A, 2'b01);
    op(0, 2, 24'h40, 0, 2'b01);
    // R5 chip-select acknowledge, wait states, alternating width
    dev_mode = 2; dev_cs = 1; dev_wait = 2;
    op(1, 3, 24'h51, 32'h0077_8899, 2'b01);
    op(0, 4, 24'h50, 0, 2'b01);
    dev_cs = 0; dev_wait = 1;
    op(0, 4, 24'h61, 0, 2'b01);
    // R4 address spaces
    dev_mode = 1; dev_wait = 0;
    op(0, 2, 24'h70, 0, 2'b10);
    op(0, 1, 24'h73, 0, 2'b11);
    op(1, 2, 24'h74, 32'h0000_4455, 2'b00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule